// File: doc/BRIEF.md
# Partial-Word Load/Store Byte Merger

This combinational unit serves the left and right partial-word instructions of a 32-bit little-endian core. These instructions move part of a word to or from an unaligned address. For a load, it merges bytes of the aligned memory word into the old value of the destination register. For a store, it merges bytes of the register into the aligned memory word, and the result is written back to memory. The number of bytes and their lanes depend on the low address bits (`byte_off`) and on which half of the pair is executing (`is_right`).

The old destination value is not always the register-file value. If a delayed load to the same register is still pending, its value is used. A second partial load in the delay slot therefore builds on the first one. The merged load result does not go straight to the register file. It is issued as a delayed-load request, in the same way as other loads. A request to register zero is suppressed. Address generation and the memory port are outside this unit. The unit receives the word already read from the aligned address.

Top module: `uwl_merge`

## Requirements
- R1: Left load with byte offset o (0..3) and shift s = 8*o: `load_value = (old & (0x00FFFFFF >> s)) | (mem_word << (24 - s))`. At o = 3 the whole word comes from memory.
- R2: Right load: `load_value = (old & (0xFFFFFF00 << (24 - s))) | (mem_word >> s)`. At o = 0 the whole word comes from memory.
- R3: Left store: `store_word = (mem_word & (0xFFFFFF00 << s)) | (rf_value >> (24 - s))`. At o = 3 the whole word is the register value.
- R4: Right store: `store_word = (mem_word & (0x00FFFFFF >> (24 - s))) | (rf_value << s)`. At o = 0 the whole word is the register value.
- R5: The old value for a load is `pend_value` when `pend_valid` = 1 and `pend_reg == dest_reg`.
- R6: The old value for a load is `rf_value` when `pend_valid` = 0, or when `pend_reg` differs from `dest_reg`.
- R7: During a load (`op_valid` = 1, `is_store` = 0), the merged value is issued as a delayed-load request. `load_req` = 1, `load_reg = dest_reg`, and `store_req` = 0.
- R8: `load_req` = 0 when `dest_reg` = 0, whatever the other inputs are.
- R9: During a store (`op_valid` = 1, `is_store` = 1), `store_req` = 1 and `load_req` = 0. When `op_valid` = 0, both requests are 0.
- R10: No mask is formed by a shift of the full word width. Every offset produces a defined value, including the two end offsets (0 and 3) of each direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_valid | input | 1 | A partial-word instruction executes this cycle |
| is_store | input | 1 | 1 = store, 0 = load |
| is_right | input | 1 | 1 = right variant, 0 = left variant |
| byte_off | input | 2 | Low address bits (byte offset within the word) |
| mem_word | input | 32 | Word read from the aligned address |
| rf_value | input | 32 | Register-file value of the destination/source register |
| dest_reg | input | 5 | Destination (load) or source (store) register index |
| pend_valid | input | 1 | A delayed load is pending |
| pend_reg | input | 5 | Register of the pending delayed load |
| pend_value | input | 32 | Value of the pending delayed load |
| load_value | output | 32 | Merged register value for the delayed-load path |
| load_req | output | 1 | Delayed-load write request |
| load_reg | output | 5 | Register targeted by the request |
| store_word | output | 32 | Merged word to write to memory |
| store_req | output | 1 | Memory write request |

## Verification
The hardest case is a pending delayed load whose register matches the destination while `rf_value` holds a different, stale value. It only arises when two partial loads to the same register are back to back. The stimulus sets the pending register and the destination to the same index, with distinct `pend_value` and `rf_value` patterns. It then repeats the case with the indices off by one, and again with `pend_valid` low. This shows which source filled each kept byte lane. All four end offsets are swept for every direction and kind.

// File: rtl/uwl_merge.sv
module uwl_merge #(
  parameter int W  = 32,
  parameter int RA = 5,
  localparam int NB = W / 8,
  localparam int OW = $clog2(NB)
) (
  input  logic          op_valid,
  input  logic          is_store,
  input  logic          is_right,
  input  logic [OW-1:0] byte_off,
  input  logic [W-1:0]  mem_word,
  input  logic [W-1:0]  rf_value,
  input  logic [RA-1:0] dest_reg,
  input  logic          pend_valid,
  input  logic [RA-1:0] pend_reg,
  input  logic [W-1:0]  pend_value,
  output logic [W-1:0]  load_value,
  output logic          load_req,
  output logic [RA-1:0] load_reg,
  output logic [W-1:0]  store_word,
  output logic          store_req
);

  localparam int SW = $clog2(W);

  logic [W-1:0] old_val, mem_up, mem_dn, reg_dn, reg_up;
  logic [SW-1:0] sh_lo, sh_hi;
  int oi;

  always_comb begin
    oi      = int'(byte_off);
    sh_lo   = SW'(8 * oi);
    sh_hi   = SW'(8 * (NB - 1 - oi));
    old_val = (pend_valid && pend_reg == dest_reg) ? pend_value : rf_value;
    mem_up  = mem_word << sh_hi;
    mem_dn  = mem_word >> sh_lo;
    reg_dn  = rf_value >> sh_hi;
    reg_up  = rf_value << sh_lo;

    for (int j = 0; j < NB; j++) begin
      if (!is_right)
        load_value[8*j +: 8] = (j >= NB - 1 - oi) ? mem_up[8*j +: 8] : old_val[8*j +: 8];
      else
        load_value[8*j +: 8] = (j <= NB - 1 - oi) ? mem_dn[8*j +: 8] : old_val[8*j +: 8];
      if (!is_right)
        store_word[8*j +: 8] = (j <= oi) ? reg_dn[8*j +: 8] : mem_word[8*j +: 8];
      else
        store_word[8*j +: 8] = (j >= oi) ? reg_up[8*j +: 8] : mem_word[8*j +: 8];
    end

    load_req  = op_valid && !is_store && (dest_reg != '0);
    load_reg  = dest_reg;
    store_req = op_valid && is_store;

    if (!is_right) begin
      assert_left_top_lane_R1: assert (load_value[W-1 -: 8] == mem_word[8*oi +: 8]);
      assert_left_store_low_lane_R3: assert (store_word[7:0] == rf_value[8*(NB-1-oi) +: 8]);
    end else begin
      assert_right_low_lane_R2: assert (load_value[7:0] == mem_word[8*oi +: 8]);
      assert_right_store_top_lane_R4: assert (store_word[W-1 -: 8] == rf_value[W-1-8*oi -: 8]);
    end
    if (byte_off == OW'(NB - 1) && !is_right) begin
      assert_full_word_load_R10: assert (load_value == mem_word);
    end
    if (dest_reg == '0) begin
      assert_no_zero_write_R8: assert (!load_req);
    end
    assert_req_exclusive_R9: assert (!(load_req && store_req));
  end

endmodule

// File: tb/tb_uwl_merge.sv
module tb_uwl_merge;

  logic        clk = 1'b0;
  always #4 clk = ~clk;

  logic        op_valid, is_store, is_right, pend_valid;
  logic [1:0]  byte_off;
  logic [31:0] mem_word, rf_value, pend_value;
  logic [4:0]  dest_reg, pend_reg;
  logic [31:0] load_value, store_word;
  logic        load_req, store_req;
  logic [4:0]  load_reg;

  uwl_merge dut (
    .op_valid(op_valid), .is_store(is_store), .is_right(is_right), .byte_off(byte_off),
    .mem_word(mem_word), .rf_value(rf_value), .dest_reg(dest_reg), .pend_valid(pend_valid),
    .pend_reg(pend_reg), .pend_value(pend_value), .load_value(load_value), .load_req(load_req),
    .load_reg(load_reg), .store_word(store_word), .store_req(store_req)
  );

  typedef struct {
    logic [31:0] lv;
    logic [31:0] sw;
    logic        lr;
    logic        sr;
    logic [4:0]  rg;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [31:0] nxt(logic [31:0] x);
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic drive(input bit v, input bit st, input bit rt, input int off,
                       input logic [31:0] m, input logic [31:0] r, input logic [4:0] d,
                       input bit pv, input logic [4:0] pr, input logic [31:0] pval,
                       input string tag);
    exp_t e;
    logic [31:0] old;
    int s;
    @(posedge clk); #1;
    op_valid = v; is_store = st; is_right = rt; byte_off = 2'(off);
    mem_word = m; rf_value = r; dest_reg = d; pend_valid = pv; pend_reg = pr; pend_value = pval;
    s = 8 * off;
    old = (pv && pr == d) ? pval : r;
    if (!rt) e.lv = (old & (32'h00FFFFFF >> s)) | (m << (24 - s));
    else     e.lv = (old & (32'hFFFFFF00 << (24 - s))) | (m >> s);
    if (!rt) e.sw = (m & (32'hFFFFFF00 << s)) | (r >> (24 - s));
    else     e.sw = (m & (32'h00FFFFFF >> (24 - s))) | (r << s);
    e.lr  = v && !st && d != 0;
    e.sr  = v && st;
    e.rg  = d;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      if (!is_store || !op_valid) chk({e.tag, " load_value"}, load_value, e.lv);
      if (is_store || !op_valid)  chk({e.tag, " store_word"}, store_word, e.sw);
      chk({e.tag, " load_req R7 R8"}, 32'(load_req), 32'(e.lr));
      chk({e.tag, " store_req R9"}, 32'(store_req), 32'(e.sr));
      chk({e.tag, " load_reg R7"}, 32'(load_reg), 32'(e.rg));
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    op_valid = 0; is_store = 0; is_right = 0; byte_off = 0; mem_word = 0; rf_value = 0;
    dest_reg = 0; pend_valid = 0; pend_reg = 0; pend_value = 0;
    drive(0, 0, 0, 0, 32'h0, 32'h0, 5'd0, 0, 5'd0, 32'h0, "reset idle R9");

    for (int off = 0; off < 4; off++) begin
      drive(1, 0, 0, off, 32'hA1B2C3D4, 32'h11223344, 5'd7, 0, 5'd0, 32'h0, "left load R1 R10");
      drive(1, 0, 1, off, 32'hA1B2C3D4, 32'h11223344, 5'd7, 0, 5'd0, 32'h0, "right load R2 R10");
      drive(1, 1, 0, off, 32'hA1B2C3D4, 32'h11223344, 5'd7, 0, 5'd0, 32'h0, "left store R3 R10");
      drive(1, 1, 1, off, 32'hA1B2C3D4, 32'h11223344, 5'd7, 0, 5'd0, 32'h0, "right store R4 R10");
    end

    for (int off = 0; off < 4; off++) begin
      drive(1, 0, 0, off, 32'hCAFEF00D, 32'h55555555, 5'd9, 1, 5'd9, 32'hDEADBEEF, "left bypass R5");
      drive(1, 0, 1, off, 32'hCAFEF00D, 32'h55555555, 5'd9, 1, 5'd9, 32'hDEADBEEF, "right bypass R5");
      drive(1, 0, 0, off, 32'hCAFEF00D, 32'h55555555, 5'd9, 1, 5'd8, 32'hDEADBEEF, "reg mismatch R6");
      drive(1, 0, 1, off, 32'hCAFEF00D, 32'h55555555, 5'd9, 0, 5'd9, 32'hDEADBEEF, "pend invalid R6");
    end

    drive(1, 0, 0, 1, 32'h01020304, 32'hF0F0F0F0, 5'd0, 0, 5'd0, 32'h0, "zero dest R8");
    drive(1, 0, 1, 2, 32'h01020304, 32'hF0F0F0F0, 5'd0, 1, 5'd0, 32'h77777777, "zero dest bypass R8");
    drive(0, 0, 0, 2, 32'h01020304, 32'hF0F0F0F0, 5'd4, 0, 5'd0, 32'h0, "no op R9");

    for (int i = 0; i < 200; i++) begin
      logic [31:0] a, b, c;
      seed = nxt(seed); a = seed;
      seed = nxt(seed); b = seed;
      seed = nxt(seed); c = seed;
      drive(1, a[0], a[1], int'(a[3:2]), b, c, a[8:4], a[9], {a[12:10], a[5:4]}, ~b ^ c,
            "random R1 R2 R3 R4 R5 R6 R7");
    end

    @(posedge clk); @(posedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule